// File: doc/BRIEF.md
# Packet Payload Statistics Monitor

This block sits beside a 64-bit AXI4-Stream packet bus and watches it without taking part in the handshake. It only has inputs from the bus, so adding it to a link cannot change a single transfer. For every packet it works out the number of payload words, their running sum, their XOR checksum, and the smallest and largest payload word. It also reports the decoded header word and, when the header asks for one, the timestamp word.

The first accepted word of a packet is the header. Bit 61 of the header says that the next accepted word is a timestamp. Neither the header nor the timestamp is counted as payload. Every accepted word after them, up to and including the word that carries tlast, goes into the statistics.

One cycle after the transfer that carries tlast, the block raises a one-cycle result strobe. The result outputs then hold still until the next strobe. The running accumulators clear at that point, so the next packet starts from fresh values.

Top module: `pkt_stats_monitor`

## Requirements
- R1: A word takes part only in a cycle where tvalid and tready are both 1. Cycles with either one low change nothing, whatever tdata and tlast carry. The block has no output toward the bus.
- R2: The first accepted word of a packet is the header and is never counted as payload. It is reported as type [63:62], timestamp flag [61], end-of-burst [60], sequence [59:48], length [47:32], source [31:16] and destination [15:0].
- R3: When header bit 61 is 1, the next accepted word is the timestamp. It is reported on the timestamp output and kept out of the statistics. When bit 61 is 0, the reported timestamp is 0.
- R4: The beat count is 32 bits and counts payload words. The sum is the 64-bit sum of the payload words modulo 2^64.
- R5: The checksum output is the bitwise XOR of all payload words.
- R6: Minimum and maximum compare words as unsigned numbers. They start each packet at 0x7FFFFFFFFFFFFFFF and 0 respectively, so a packet whose words all have bit 63 set reports the starting minimum.
- R7: The payload word that carries tlast is included in the statistics.
- R8: A packet that ends on its header word, or on its timestamp word, reports count, sum and XOR of 0, a minimum of 0x7FFFFFFFFFFFFFFF and a maximum of 0. The header is still reported.
- R9: The result strobe is high for exactly the one cycle after each tlast transfer and at no other time. Back-to-back packets give back-to-back strobes. The result outputs change only in a strobe cycle.
- R10: After each packet the accumulators clear, so the next packet's results do not depend on earlier packets.
- R11: Reset drops the strobe, sets the results to their starting values (counts, sum, XOR, maximum, header and timestamp 0, minimum 0x7FFFFFFFFFFFFFFF), and makes the next accepted word a header, even if reset arrives in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Observed tvalid |
| s_tready | input | 1 | Observed tready |
| s_tdata | input | 64 | Observed tdata |
| s_tlast | input | 1 | Observed tlast |
| res_done | output | 1 | One-cycle result strobe |
| res_beats | output | 32 | Payload word count |
| res_sum | output | 64 | Payload sum modulo 2^64 |
| res_xor | output | 64 | Payload XOR checksum |
| res_min | output | 64 | Smallest payload word, unsigned |
| res_max | output | 64 | Largest payload word, unsigned |
| res_kind | output | 2 | Header type field |
| res_has_ts | output | 1 | Header timestamp flag |
| res_end_burst | output | 1 | Header end-of-burst flag |
| res_seq | output | 12 | Header sequence number |
| res_len | output | 16 | Header length field |
| res_src | output | 16 | Header source id |
| res_dst | output | 16 | Header destination id |
| res_timestamp | output | 64 | Timestamp word, or 0 |

## Verification
The bench covers the following corner cases, and for each one the failure a faulty design would show:
- **Header-only and timestamp-ending packets.** A faulty design would count the header or timestamp as payload and report a nonzero count.
- **Stalled and idle cycles with random tdata and tlast.** A design that does not check both handshake signals would pick up extra words or raise stray strobes.
- **Payload words with bit 63 set.** A signed compare, or a minimum that does not start at 0x7FFFFFFFFFFFFFFF, would report the wrong minimum.
- **A pair of words whose sum wraps past 2^64.** A wrong width would break the wrapped sum.
- **A reset in the middle of a packet, followed by a fresh packet.** A parser that is not sent back to the header state would decode the wrong word as the header.
- **Back-to-back header-only packets.** A design that does not give one strobe per packet would merge or drop strobes.

// File: rtl/pkt_stats_pkg.sv
package pkt_stats_pkg;

  localparam int unsigned WORD_W      = 64;
  localparam int unsigned CNT_W       = 32;
  localparam int unsigned TS_FLAG_BIT = 61;

  typedef logic [WORD_W-1:0] word_t;

  // header layout; the field order is what the decoder depends on
  typedef struct packed {
    logic [1:0]  kind;
    logic        has_ts;
    logic        end_burst;
    logic [11:0] seq;
    logic [15:0] len;
    logic [15:0] src;
    logic [15:0] dst;
  } hdr_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    word_t            sum;
    word_t            chk;
    word_t            mn;
    word_t            mx;
  } stats_t;

  typedef enum logic [1:0] {PS_HDR, PS_TS, PS_PAY} parse_t;

  localparam word_t MIN_SEED = {1'b0, {(WORD_W-1){1'b1}}};

  function automatic stats_t stats_init();
    stats_t s;
    s.cnt = '0;
    s.sum = '0;
    s.chk = '0;
    s.mn  = MIN_SEED;
    s.mx  = '0;
    return s;
  endfunction

  function automatic word_t umin(word_t a, word_t b);
    return (b < a) ? b : a;
  endfunction

  function automatic word_t umax(word_t a, word_t b);
    return (b > a) ? b : a;
  endfunction

  function automatic stats_t stats_fold(stats_t s, word_t w);
    stats_t r;
    r.cnt = s.cnt + 1'b1;
    r.sum = s.sum + w;
    r.chk = s.chk ^ w;
    r.mn  = umin(s.mn, w);
    r.mx  = umax(s.mx, w);
    return r;
  endfunction

endpackage

// File: rtl/pkt_beat_classifier.sv
module pkt_beat_classifier
  import pkt_stats_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic last,
  input  logic ts_flag,
  output logic hdr_fire,
  output logic ts_fire,
  output logic pay_fire,
  output logic pkt_end
);

  parse_t st_q;
  parse_t st_d;

  assign hdr_fire = xfer && (st_q == PS_HDR);
  assign ts_fire  = xfer && (st_q == PS_TS);
  assign pay_fire = xfer && (st_q == PS_PAY);
  assign pkt_end  = xfer && last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_HDR: if (xfer && !last) st_d = ts_flag ? PS_TS : PS_PAY;
      PS_TS:  if (xfer) st_d = last ? PS_HDR : PS_PAY;
      PS_PAY: if (xfer && last) st_d = PS_HDR;
      default: st_d = PS_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= PS_HDR;
    else        st_q <= st_d;
  end

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_fire, ts_fire, pay_fire})); // R2
  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> !(hdr_fire || ts_fire || pay_fire || pkt_end)); // R1
  AST_END_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (st_q == PS_HDR)); // R10

endmodule

// File: rtl/pkt_stats_accum.sv
module pkt_stats_accum
  import pkt_stats_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pay_fire,
  input  logic   pkt_end,
  input  word_t  word,
  output stats_t fin
);

  stats_t acc_q;
  stats_t folded;

  assign folded = stats_fold(acc_q, word);
  assign fin    = pay_fire ? folded : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= stats_init();
    else if (pkt_end) acc_q <= stats_init();
    else if (pay_fire) acc_q <= folded;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_fire && !pkt_end) |=> (acc_q.cnt == $past(acc_q.cnt) + 1'b1)); // R4
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pay_fire && !pkt_end) |=> $stable(acc_q)); // R1
  AST_CLEAR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (acc_q == stats_init())); // R10
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q.cnt != '0) |-> (acc_q.mn <= acc_q.mx)); // R6

endmodule

// File: rtl/pkt_result_hold.sv
module pkt_result_hold
  import pkt_stats_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hdr_fire,
  input  logic   ts_fire,
  input  logic   pkt_end,
  input  word_t  word,
  input  stats_t fin,
  output logic   done,
  output stats_t out_stats,
  output hdr_t   out_hdr,
  output word_t  out_ts
);

  hdr_t  cur_hdr;
  word_t cur_ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_hdr <= '0;
      cur_ts  <= '0;
    end else if (hdr_fire) begin
      cur_hdr <= hdr_t'(word);
      cur_ts  <= '0;
    end else if (ts_fire) begin
      cur_ts  <= word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      out_stats <= stats_init();
      out_hdr   <= '0;
      out_ts    <= '0;
    end else begin
      done <= pkt_end;
      if (pkt_end) begin
        out_stats <= fin;
        out_hdr   <= hdr_fire ? hdr_t'(word) : cur_hdr;
        out_ts    <= hdr_fire ? '0 : (ts_fire ? word : cur_ts);
      end
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_stats) && $stable(out_hdr) && $stable(out_ts))); // R9
  AST_HDR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && pkt_end) |=> (out_stats.cnt == '0 && out_ts == '0)); // R8

endmodule

// File: rtl/pkt_stats_monitor.sv
module pkt_stats_monitor
  import pkt_stats_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_tvalid,
  input  logic               s_tready,
  input  logic [WORD_W-1:0]  s_tdata,
  input  logic               s_tlast,
  output logic               res_done,
  output logic [CNT_W-1:0]   res_beats,
  output logic [WORD_W-1:0]  res_sum,
  output logic [WORD_W-1:0]  res_xor,
  output logic [WORD_W-1:0]  res_min,
  output logic [WORD_W-1:0]  res_max,
  output logic [1:0]         res_kind,
  output logic               res_has_ts,
  output logic               res_end_burst,
  output logic [11:0]        res_seq,
  output logic [15:0]        res_len,
  output logic [15:0]        res_src,
  output logic [15:0]        res_dst,
  output logic [WORD_W-1:0]  res_timestamp
);

  logic   xfer;
  logic   hdr_fire, ts_fire, pay_fire, pkt_end;
  stats_t fin;
  stats_t out_stats;
  hdr_t   out_hdr;

  assign xfer = s_tvalid && s_tready;

  pkt_beat_classifier u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .last     (s_tlast),
    .ts_flag  (s_tdata[TS_FLAG_BIT]),
    .hdr_fire (hdr_fire),
    .ts_fire  (ts_fire),
    .pay_fire (pay_fire),
    .pkt_end  (pkt_end)
  );

  pkt_stats_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pay_fire (pay_fire),
    .pkt_end  (pkt_end),
    .word     (s_tdata),
    .fin      (fin)
  );

  pkt_result_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_fire  (hdr_fire),
    .ts_fire   (ts_fire),
    .pkt_end   (pkt_end),
    .word      (s_tdata),
    .fin       (fin),
    .done      (res_done),
    .out_stats (out_stats),
    .out_hdr   (out_hdr),
    .out_ts    (res_timestamp)
  );

  assign res_beats     = out_stats.cnt;
  assign res_sum       = out_stats.sum;
  assign res_xor       = out_stats.chk;
  assign res_min       = out_stats.mn;
  assign res_max       = out_stats.mx;
  assign res_kind      = out_hdr.kind;
  assign res_has_ts    = out_hdr.has_ts;
  assign res_end_burst = out_hdr.end_burst;
  assign res_seq       = out_hdr.seq;
  assign res_len       = out_hdr.len;
  assign res_src       = out_hdr.src;
  assign res_dst       = out_hdr.dst;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> res_done); // R9
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tvalid && s_tready && s_tlast) |=> !res_done); // R9

endmodule

// File: tb/pkt_stats_monitor_tb.sv
module pkt_stats_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tvalid = 1'b0, tready = 1'b0, tlast = 1'b0;
  logic [63:0] tdata = '0;
  logic        res_done;
  logic [31:0] res_beats;
  logic [63:0] res_sum, res_xor, res_min, res_max, res_timestamp;
  logic [1:0]  res_kind;
  logic        res_has_ts, res_end_burst;
  logic [11:0] res_seq;
  logic [15:0] res_len, res_src, res_dst;

  localparam logic [63:0] MIN0 = 64'h7FFF_FFFF_FFFF_FFFF;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] pk [0:31];
  logic [31:0] e_cnt;
  logic [63:0] e_sum, e_xor, e_min, e_max, e_ts, e_hdr;
  logic [31:0] h_cnt;
  logic [63:0] h_sum, h_min, h_max;

  always #2 clk = ~clk;

  pkt_stats_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .s_tvalid(tvalid), .s_tready(tready),
    .s_tdata(tdata), .s_tlast(tlast), .res_done(res_done),
    .res_beats(res_beats), .res_sum(res_sum), .res_xor(res_xor),
    .res_min(res_min), .res_max(res_max), .res_kind(res_kind),
    .res_has_ts(res_has_ts), .res_end_burst(res_end_burst),
    .res_seq(res_seq), .res_len(res_len), .res_src(res_src),
    .res_dst(res_dst), .res_timestamp(res_timestamp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd_word();
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    case ($urandom_range(0, 3))
      0: w = w & 64'hFF;
      1: w[63] = 1'b0;
      default: ;
    endcase
    return w;
  endfunction

  // expected result from the requirements
  task automatic model(input int n);
    int start;
    e_hdr = pk[0];
    e_ts  = (pk[0][61] && n >= 2) ? pk[1] : 64'd0;
    start = pk[0][61] ? 2 : 1;
    e_cnt = 0; e_sum = 0; e_xor = 0; e_min = MIN0; e_max = 0;
    for (int i = start; i < n; i++) begin
      e_cnt = e_cnt + 1;
      e_sum = e_sum + pk[i];
      e_xor = e_xor ^ pk[i];
      if (pk[i] < e_min) e_min = pk[i];
      if (pk[i] > e_max) e_max = pk[i];
    end
  endtask

  task automatic step(input bit v, input bit r, input logic [63:0] d, input bit l);
    bit ed;
    tvalid = v; tready = r; tdata = d; tlast = l;
    @(negedge clk);
    ed = v && r && l;
    chk(res_done == ed, "R9", "done strobe", {63'd0, res_done}, {63'd0, ed});
    if (ed) begin
      chk(res_beats == e_cnt, "R4", "beat count", {32'd0, res_beats}, {32'd0, e_cnt});
      chk(res_sum == e_sum, "R4", "sum", res_sum, e_sum);
      chk(res_xor == e_xor, "R5", "xor", res_xor, e_xor);
      chk(res_min == e_min, "R6", "min", res_min, e_min);
      chk(res_max == e_max, "R6", "max", res_max, e_max);
      chk({res_kind, res_has_ts, res_end_burst, res_seq, res_len, res_src, res_dst} == e_hdr,
          "R2", "header", {res_kind, res_has_ts, res_end_burst, res_seq, res_len, res_src, res_dst}, e_hdr);
      chk(res_timestamp == e_ts, "R3", "timestamp", res_timestamp, e_ts);
      h_cnt = e_cnt; h_sum = e_sum; h_min = e_min; h_max = e_max;
    end else begin
      chk(res_sum == h_sum && res_beats == h_cnt && res_min == h_min && res_max == h_max,
          "R9", "outputs held", res_sum, h_sum);
    end
  endtask

  task automatic send(input int n, input int gap_pct, input int stall_pct);
    model(n);
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(0, 99) < gap_pct)
        step(1'b0, $urandom_range(0, 1) == 1, rnd_word(), $urandom_range(0, 1) == 1); // R1
      while ($urandom_range(0, 99) < stall_pct)
        step(1'b1, 1'b0, rnd_word(), $urandom_range(0, 1) == 1); // R1
      step(1'b1, 1'b1, pk[i], i == n - 1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tvalid = 0; tready = 0; tlast = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    h_cnt = 0; h_sum = 0; h_min = MIN0; h_max = 0;
    chk(res_done == 1'b0, "R11", "reset done", {63'd0, res_done}, 64'd0);
    chk(res_beats == 0 && res_sum == 0 && res_xor == 0, "R11", "reset count/sum/xor", res_sum, 64'd0);
    chk(res_min == MIN0, "R11", "reset min", res_min, MIN0);
    chk(res_max == 0 && res_timestamp == 0, "R11", "reset max/ts", res_max, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R8: header-only packet with timestamp flag set
    pk[0] = 64'hA000_0123_4567_89AB | (64'd1 << 61);
    send(1, 0, 0);
    // R8: packet ending on the timestamp word
    pk[0] = 64'h2000_0000_0010_0002; pk[1] = 64'hDEAD_BEEF_0000_0001;
    send(2, 30, 30);
    // R7: single payload word carrying tlast
    pk[0] = 64'h0001_0008_0004_0005; pk[1] = 64'h55;
    send(2, 0, 0);
    // R3: timestamp packet with three payload words
    pk[0] = 64'h6123_0020_0007_0009; pk[1] = 64'h1111_2222_3333_4444;
    pk[2] = 64'h10; pk[3] = 64'h3; pk[4] = 64'h7;
    send(5, 20, 20);
    // R6: all payload words have bit 63 set
    pk[0] = 64'h0; pk[1] = 64'h8000_0000_0000_0005; pk[2] = 64'hF000_0000_0000_0000;
    send(3, 0, 0);
    // R4: sum wraps past 2^64
    pk[0] = 64'h0; pk[1] = 64'hFFFF_FFFF_FFFF_FFFF; pk[2] = 64'h2;
    send(3, 0, 0);
    // R9: back-to-back header-only packets
    for (int k = 0; k < 4; k++) begin
      pk[0] = {32'd0, 32'(k)};
      send(1, 0, 0);
    end

    // R11: reset in mid-packet, then a fresh packet decodes correctly
    tvalid = 1; tready = 1; tlast = 0; tdata = 64'h2000_0000_0000_0000;
    @(negedge clk);
    tdata = 64'h1234; @(negedge clk);
    tdata = 64'h99; @(negedge clk);
    do_reset();
    pk[0] = 64'h0000_0000_0000_0077; pk[1] = 64'h4; pk[2] = 64'h9;
    send(3, 0, 0); // R11 / R10

    // random packets
    for (int p = 0; p < 250; p++) begin
      int n;
      n = $urandom_range(1, 12);
      pk[0] = {$urandom(), $urandom()};
      pk[0][61] = ($urandom_range(0, 2) == 0);
      for (int i = 1; i < n; i++) pk[i] = rnd_word();
      send(n, $urandom_range(0, 40), $urandom_range(0, 40)); // R10
    end

    step(1'b0, 1'b0, 64'd0, 1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule